// File: doc/BRIEF.md
# Transfer-Completion Interrupt Request Generator

This block produces the single interrupt request line of a disk or tape bus adapter. It merges two kinds of request. The first is a completion request that is captured in an internal request flip-flop, so that it fires on an edge. The second is a special-condition request that follows a level. The completion request, once captured, stays pending until software acknowledges it or clears the controller, even if the enable bit is dropped in the meantime. The special-condition request is gated by the enable bit and by the completion status bit at all times.

The block holds four pieces of state:
- the interrupt-enable bit;
- the completion bit;
- the request flip-flop;
- a sticky transfer-error bit.

Software writes the enable bit through a control-register write strobe. The transfer engine sets and clears the completion bit through event pulses. Error flags from the second status register arrive as a vector. The special-condition level combines those flags, the sticky transfer-error bit and a device attention input. Controller clear, bus init and interrupt acknowledge return the request logic to a quiet state.

Top module: `xfer_irq_gen`

## Requirements
- R1: While and after reset: completion bit = 1, enable = 0, request flip-flop = 0, transfer error = 0, request line = 0.
- R2: A control write (`csr_wr` = 1) whose data has both `wr_ie` = 1 and `wr_done` = 1 sets the request flip-flop at the next clock edge. A write with only one of the two bits set leaves the flip-flop unchanged.
- R3: When the completion bit goes from 0 to 1, the request flip-flop takes the enable value held before that edge. It becomes 1 if enable was 1 and 0 if enable was 0.
- R4: `int_ack` clears both the request flip-flop and the enable bit. It wins over a write that would set the flip-flop, and over a completion rise in the same cycle.
- R5: `ctl_clr` or `bus_init` each restore the R1 state at the next clock edge: completion = 1, enable = 0, flip-flop = 0, sticky transfer error = 0.
- R6: `irq` is 1 exactly when the flip-flop is 1, or when special condition, completion and enable are all 1. A completion bit of 0 blocks the special-condition request.
- R7: Clearing enable through a control write does not drop a pending flip-flop request. It does drop a special-condition request.
- R8: The special condition `sc` is 1 whenever `attn` is 1, any bit of `err` is 1, or the transfer error is 1.
- R9: Any set `err` bit forces `tre` to 1 in the same cycle and sets the sticky transfer error. The sticky bit is also set by `tre_set`. It is cleared by `tre_clr` only when no `err` bit is set in that cycle.
- R10: A control write loads enable from `wr_ie`. `done_set` sets the completion bit, `done_clr` clears it, and `done_set` wins when both are pulsed together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_wr | input | 1 | Control register write strobe |
| wr_ie | input | 1 | Enable bit of the write data |
| wr_done | input | 1 | Completion bit of the write data |
| done_set | input | 1 | Transfer engine marks completion |
| done_clr | input | 1 | Transfer engine starts a transfer |
| attn | input | 1 | Device attention level |
| err | input | ERR_W | Error flags of status register 2 |
| tre_set | input | 1 | Transfer engine reports a transfer error |
| tre_clr | input | 1 | Software error-clear pulse |
| ctl_clr | input | 1 | Controller clear |
| bus_init | input | 1 | Bus initialize |
| int_ack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request |
| ie | output | 1 | Enable bit readback |
| done | output | 1 | Completion bit readback |
| flop | output | 1 | Request flip-flop readback |
| tre | output | 1 | Transfer error readback |
| sc | output | 1 | Special condition readback |

## Verification
The bench builds the block with `ERR_W` = 3. This keeps a walk of every single error flag short, so each flag is shown to force the transfer error and the special condition on its own. It also reaches the sticky-error cases, both with and without a clear pulse competing with a live flag. The event sequences include completion rises under both enable values, an acknowledge that coincides with a completion rise, and an enable drop while each kind of request is pending.

// File: rtl/xfer_irq_gen.sv
module xfer_irq_gen #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr,
  input  logic             wr_ie,
  input  logic             wr_done,
  input  logic             done_set,
  input  logic             done_clr,
  input  logic             attn,
  input  logic [ERR_W-1:0] err,
  input  logic             tre_set,
  input  logic             tre_clr,
  input  logic             ctl_clr,
  input  logic             bus_init,
  input  logic             int_ack,
  output logic             irq,
  output logic             ie,
  output logic             done,
  output logic             flop,
  output logic             tre,
  output logic             sc
);

  logic ie_q, done_q, flop_q, tre_q;

  wire err_any   = |err;
  wire wipe      = ctl_clr | bus_init;
  wire done_rise = done_set & ~done_q;
  wire wr_arm    = csr_wr & wr_ie & wr_done;

  assign tre  = tre_q | err_any;
  assign sc   = attn | tre;
  assign irq  = flop_q | (sc & done_q & ie_q);
  assign ie   = ie_q;
  assign done = done_q;
  assign flop = flop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || wipe) begin
      ie_q   <= 1'b0;
      done_q <= 1'b1;
      flop_q <= 1'b0;
      tre_q  <= 1'b0;
    end else begin
      if (int_ack)        flop_q <= 1'b0;
      else if (wr_arm)    flop_q <= 1'b1;
      else if (done_rise) flop_q <= ie_q;

      if (int_ack)     ie_q <= 1'b0;
      else if (csr_wr) ie_q <= wr_ie;

      if (done_set)      done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;

      if (tre_set || err_any) tre_q <= 1'b1;
      else if (tre_clr)       tre_q <= 1'b0;
    end
  end

endmodule

module xfer_irq_gen_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csr_wr,
  input logic             wr_ie,
  input logic             wr_done,
  input logic             done_set,
  input logic [ERR_W-1:0] err,
  input logic             ctl_clr,
  input logic             bus_init,
  input logic             int_ack,
  input logic             irq,
  input logic             ie,
  input logic             done,
  input logic             flop,
  input logic             tre,
  input logic             sc
);

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> (!flop && !ie)); // R4

  AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && wr_ie && wr_done && !int_ack && !ctl_clr && !bus_init) |=> flop); // R2

  AST_DONE_EDGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && done_set && !int_ack && !ctl_clr && !bus_init && !(csr_wr && wr_ie && wr_done))
    |=> (flop == $past(ie))); // R3

  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_clr || bus_init) |=> (done && !ie && !flop)); // R5

  AST_FLOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flop && !int_ack && !ctl_clr && !bus_init && !(!done && done_set)) |=> flop); // R7

  AST_QUIET_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!flop && !ie) |-> !irq); // R6

  AST_ERR_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    (|err) |-> (tre && sc)); // R9

endmodule

bind xfer_irq_gen xfer_irq_gen_chk #(.ERR_W(ERR_W)) u_chk (.*);

// File: tb/xfer_irq_gen_bench.sv
module xfer_irq_gen_bench;
  localparam int EW = 3;

  typedef struct packed {
    logic          wr, wie, wdone, dset, dclr, attn;
    logic [EW-1:0] err;
    logic          tset, tclr, cclr, init, ack;
  } stim_t;

  typedef struct {
    logic [5:0] v;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  stim_t s = '0;
  logic irq, ie, done, flop, tre, sc;
  int checks = 0;
  int errors = 0;
  exp_t q[$];
  logic m_ie = 1'b0, m_done = 1'b1, m_flop = 1'b0, m_tre = 1'b0;

  always #5 clk = ~clk;

  xfer_irq_gen #(.ERR_W(EW)) u_xfer_irq_gen (
    .clk(clk), .rst_n(rst_n), .csr_wr(s.wr), .wr_ie(s.wie), .wr_done(s.wdone),
    .done_set(s.dset), .done_clr(s.dclr), .attn(s.attn), .err(s.err),
    .tre_set(s.tset), .tre_clr(s.tclr), .ctl_clr(s.cclr), .bus_init(s.init),
    .int_ack(s.ack), .irq(irq), .ie(ie), .done(done), .flop(flop), .tre(tre), .sc(sc)
  );

  task automatic cyc(input stim_t st, input string tag);
    logic n_ie, n_done, n_flop, n_tre, o_tre, o_sc;
    exp_t e;
    @(negedge clk);
    s = st;
    if (st.cclr || st.init) begin
      n_ie = 0; n_done = 1; n_flop = 0; n_tre = 0;
    end else begin
      n_flop = st.ack ? 1'b0 : (st.wr && st.wie && st.wdone) ? 1'b1 :
               (!m_done && st.dset) ? m_ie : m_flop;
      n_ie   = st.ack ? 1'b0 : st.wr ? st.wie : m_ie;
      n_done = st.dset ? 1'b1 : st.dclr ? 1'b0 : m_done;
      n_tre  = (st.tset || (|st.err)) ? 1'b1 : st.tclr ? 1'b0 : m_tre;
    end
    m_ie = n_ie; m_done = n_done; m_flop = n_flop; m_tre = n_tre;
    o_tre = n_tre | (|st.err);
    o_sc  = st.attn | o_tre;
    e.v   = {n_flop | (o_sc & n_done & n_ie), n_ie, n_done, n_flop, o_tre, o_sc};
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        logic [5:0] act;
        e = q.pop_front();
        act = {irq, ie, done, flop, tre, sc};
        checks++;
        if (act !== e.v) begin
          errors++;
          $display("FAIL %s : irq/ie/done/flop/tre/sc actual %b expected %b", e.tag, act, e.v);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    stim_t st;
    repeat (2) @(posedge clk);
    #2;
    checks++;
    if ({irq, ie, done, flop, tre, sc} !== 6'b001000) begin
      errors++;
      $display("FAIL R1 in reset: actual %b expected 001000", {irq, ie, done, flop, tre, sc});
    end
    @(negedge clk);
    rst_n = 1'b1;

    st = '0; cyc(st, "R1 idle after reset");
    st = '0; st.wr = 1; st.wie = 1; cyc(st, "R2 enable only, no arm");
    st = '0; st.wr = 1; st.wie = 0; st.wdone = 1; cyc(st, "R2 done bit only, no arm");
    st = '0; st.wr = 1; st.wie = 1; cyc(st, "R10 enable write");
    st = '0; st.dclr = 1; cyc(st, "R10 done clear");
    st = '0; st.dset = 1; cyc(st, "R3 done rise loads enable=1");
    st = '0; st.wr = 1; st.wie = 0; cyc(st, "R7 enable drop keeps flop");
    st = '0; st.ack = 1; cyc(st, "R4 ack clears flop");
    st = '0; st.wr = 1; st.wie = 1; st.wdone = 1; cyc(st, "R2 write arms flop");
    st = '0; st.ack = 1; cyc(st, "R4 ack clears flop and enable");
    st = '0; st.wr = 1; st.wie = 1; cyc(st, "R10 enable write");
    st = '0; st.dclr = 1; cyc(st, "R10 done clear");
    st = '0; st.ack = 1; st.dset = 1; cyc(st, "R4 ack beats done rise");
    st = '0; st.wr = 1; st.wie = 1; st.wdone = 1; cyc(st, "R2 arm again");
    st = '0; st.wr = 1; st.wie = 1; st.wdone = 1; st.ack = 1; cyc(st, "R4 ack beats arming write");
    st = '0; st.wr = 1; st.wie = 1; st.wdone = 1; cyc(st, "R2 arm");
    st = '0; st.wr = 1; cyc(st, "R7 enable off, flop held");
    st = '0; st.dclr = 1; cyc(st, "R10 done clear");
    st = '0; st.dset = 1; cyc(st, "R3 done rise loads enable=0");
    st = '0; st.dset = 1; cyc(st, "R3 done already set, no reload");
    st = '0; st.wr = 1; st.wie = 1; cyc(st, "R10 enable on");
    st = '0; st.attn = 1; cyc(st, "R8 attention gives sc request");
    st = '0; st.attn = 1; st.wr = 1; cyc(st, "R7 enable drop removes sc request");
    st = '0; st.wr = 1; st.wie = 1; cyc(st, "R6 enable on, no sc");
    st = '0; st.attn = 1; st.dclr = 1; cyc(st, "R6 done low blocks sc request");
    st = '0; st.dset = 1; cyc(st, "R3 done rise with enable=1");
    st = '0; st.ack = 1; cyc(st, "R4 ack");
    st = '0; st.wr = 1; st.wie = 1; cyc(st, "R10 enable on");
    for (int i = 0; i < EW; i++) begin
      st = '0; st.err = EW'(1) << i; cyc(st, "R9 err flag forces tre");
      st = '0; cyc(st, "R9 tre sticky after flag drops");
      st = '0; st.tclr = 1; cyc(st, "R9 tre clear");
    end
    st = '0; st.err = 3'b010; st.tclr = 1; cyc(st, "R9 clear loses to live flag");
    st = '0; cyc(st, "R9 still sticky");
    st = '0; st.tclr = 1; cyc(st, "R9 clear");
    st = '0; st.tset = 1; cyc(st, "R8 tre set gives sc");
    st = '0; st.dclr = 1; st.dset = 1; cyc(st, "R10 set wins over clear");
    st = '0; st.wr = 1; st.wie = 1; st.wdone = 1; cyc(st, "R2 arm");
    st = '0; st.dclr = 1; cyc(st, "R10 done clear");
    st = '0; st.cclr = 1; cyc(st, "R5 controller clear");
    st = '0; st.wr = 1; st.wie = 1; st.wdone = 1; st.tset = 1; cyc(st, "R2 arm with tre");
    st = '0; st.init = 1; st.dclr = 1; cyc(st, "R5 bus init");
    st = '0; cyc(st, "R1 quiet after init");
    repeat (3) @(posedge clk);
    #3;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule